// File: doc/BRIEF.md
# UART Register Bank and Interrupt Encoder

This block is the CPU-facing half of a simple byte-serial port. It is an 8-bit Wishbone slave with a 4-bit address. It sits between the processor bus and the serial datapath. The serial shifters and the baud generator live elsewhere. They connect to this block through level inputs (data ready, overrun, framing error, transmitter room, transmitter idle) and through single-cycle strobes (load the transmitter, pop the receiver).

The bank holds the data port, line status, modem status with a carrier-detect change flag, the interrupt enable and interrupt status bytes, modem control, a flow-control switch, four clock-multiplier bytes for the baud generator, two placeholder registers and a scratch byte. The four modem inputs are active low and asynchronous, so each one passes through a two-flop synchroniser. The two modem outputs are also active low. From the enabled sources the block reports the one with the highest priority as a code in the interrupt status byte, and it drives a single interrupt request line.

Top module: `uart_regbank`

## Requirements
- R1: `ack_o` rises on the clock edge after the first edge at which `cyc_i` and `stb_i` are both high. It stays high for exactly one cycle while the master drops `stb_i` after the acknowledge.
- R2: A write to address 0 raises `tx_load_o` for one cycle, aligned with `ack_o`, with `tx_data_o` equal to the written byte. A read from address 0 returns `rx_data_i` on `dat_o` and raises `rx_pop_o` for exactly one cycle per bus cycle.
- R3: Address 1 reads the line status: bit0 = receive data ready, bit1 = overrun, bit3 = framing error, bit5 = transmitter has room, bit6 = transmitter idle. All other bits read 0.
- R4: Address 2 reads the modem status: bit4 = CTS, bit5 = DSR, bit6 = RI, bit7 = DCD. Each is 1 when its active-low pin is driven low, after two synchroniser flops. Bits 2:0 read 0.
- R5: Bit3 of the modem status is set by any edge of the synchronised DCD level. It is cleared by any write to address 2. If an edge and a clearing write fall in the same cycle, the flag stays set.
- R6: Address 4 is the interrupt enable byte and reads back as written. Bit0 enables receive-data-ready, bit1 enables transmitter-idle and bit3 enables the DCD change flag. It resets to 0.
- R7: Address 3 reads the interrupt status byte `{pending, 2'b00, code[2:0], 2'b00}`. The code is 3'b001 for DCD change, 3'b010 for receive data and 3'b011 for transmitter idle, in that priority. Only enabled and active sources count. `irq_o` equals the pending bit.
- R8: Address 6 bit0 sets DTR and bit1 sets RTS, both driven active low on `dtr_no` and `rts_no`. The reset values come from parameters `DTR_RST` and `RTS_RST`, which default to 1 (asserted).
- R9: When bit0 of address 7 is 0, `tx_allow_o` is 1. When that bit is 1, `tx_allow_o` follows the synchronised CTS level.
- R10: Addresses 8 to 11 hold the bytes of `clk_mul_o`, least significant byte at address 8. They reset to parameter `CLK_MUL_RST` and read back as written.
- R11: Addresses 5, 12 and 15 are plain read/write storage. Addresses 13 and 14 read 0 and ignore writes.
- R12: A read of any address other than 0 raises neither `rx_pop_o` nor `tx_load_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cyc_i | input | 1 | Bus cycle valid |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | 1 = write |
| adr_i | input | 4 | Register address |
| dat_i | input | 8 | Write data |
| dat_o | output | 8 | Read data, valid with ack_o |
| ack_o | output | 1 | Transfer acknowledge |
| irq_o | output | 1 | Interrupt request |
| rx_data_i | input | 8 | Byte at the head of the receiver |
| rx_ready_i | input | 1 | Receiver holds data |
| rx_overrun_i | input | 1 | Receiver overrun seen |
| rx_frame_err_i | input | 1 | Framing error on the current byte |
| rx_pop_o | output | 1 | Pop strobe to the receiver |
| tx_room_i | input | 1 | Transmitter can accept a byte |
| tx_idle_i | input | 1 | Transmitter completely empty |
| tx_load_o | output | 1 | Load strobe to the transmitter |
| tx_data_o | output | 8 | Byte to transmit |
| tx_allow_o | output | 1 | Transmitter may send |
| clk_mul_o | output | 32 | Baud generator multiplier |
| cts_ni | input | 1 | Clear to send, active low |
| dsr_ni | input | 1 | Data set ready, active low |
| dcd_ni | input | 1 | Carrier detect, active low |
| ri_ni | input | 1 | Ring indicator, active low |
| dtr_no | output | 1 | Data terminal ready, active low |
| rts_no | output | 1 | Request to send, active low |

## Verification
Two functions can act on the DCD change flag in the same cycle: the flag is set by a carrier-detect edge coming out of the synchroniser, and it is cleared by a software write to the modem status address. The bench toggles `dcd_ni` and waits for the two synchroniser edges. It then times a write to address 2 so that its access edge is the edge on which the change is detected. The flag must survive that write, which the bench confirms by reading back a 1 in bit3 and by checking that the interrupt code is 3'b001. A later write with no edge present must clear the flag.

// File: rtl/uart_regbank.sv
module uart_regbank #(
  parameter logic [31:0] CLK_MUL_RST = 32'h0003_2A10,
  parameter bit          DTR_RST     = 1'b1,
  parameter bit          RTS_RST     = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        cyc_i,
  input  logic        stb_i,
  input  logic        we_i,
  input  logic [3:0]  adr_i,
  input  logic [7:0]  dat_i,
  output logic [7:0]  dat_o,
  output logic        ack_o,
  output logic        irq_o,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_ready_i,
  input  logic        rx_overrun_i,
  input  logic        rx_frame_err_i,
  output logic        rx_pop_o,
  input  logic        tx_room_i,
  input  logic        tx_idle_i,
  output logic        tx_load_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_allow_o,
  output logic [31:0] clk_mul_o,
  input  logic        cts_ni,
  input  logic        dsr_ni,
  input  logic        dcd_ni,
  input  logic        ri_ni,
  output logic        dtr_no,
  output logic        rts_no
);

  logic       acc, wr, rd;
  logic [3:0] pin_a, pin_b;
  logic       cts_s, dsr_s, dcd_s, ri_s, dcd_prev, dcd_chg;
  logic [7:0] ier, mcr, ctl, ffr, fcr, spr;
  logic [7:0] lsr, msr, isr, rd_mux;
  logic       src_mdm, src_rx, src_tx;
  logic [2:0] code;

  assign acc = cyc_i && stb_i && !ack_o;
  assign wr  = acc && we_i;
  assign rd  = acc && !we_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pin_a <= '0;
      pin_b <= '0;
    end else begin
      pin_a <= ~{dcd_ni, ri_ni, dsr_ni, cts_ni};
      pin_b <= pin_a;
    end
  end
  assign {dcd_s, ri_s, dsr_s, cts_s} = pin_b;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      dcd_prev <= 1'b0;
      dcd_chg  <= 1'b0;
    end else begin
      dcd_prev <= dcd_s;
      if (dcd_s != dcd_prev)
        dcd_chg <= 1'b1;
      else if (wr && adr_i == 4'd2)
        dcd_chg <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ier       <= '0;
      mcr       <= {6'b0, RTS_RST, DTR_RST};
      ctl       <= '0;
      ffr       <= '0;
      fcr       <= '0;
      spr       <= '0;
      clk_mul_o <= CLK_MUL_RST;
    end else if (wr) begin
      case (adr_i)
        4'd4:  ier <= dat_i;
        4'd5:  ffr <= dat_i;
        4'd6:  mcr <= dat_i;
        4'd7:  ctl <= dat_i;
        4'd8:  clk_mul_o[7:0]   <= dat_i;
        4'd9:  clk_mul_o[15:8]  <= dat_i;
        4'd10: clk_mul_o[23:16] <= dat_i;
        4'd11: clk_mul_o[31:24] <= dat_i;
        4'd12: fcr <= dat_i;
        4'd15: spr <= dat_i;
        default: ;
      endcase
    end
  end

  assign src_mdm = ier[3] && dcd_chg;
  assign src_rx  = ier[0] && rx_ready_i;
  assign src_tx  = ier[1] && tx_idle_i;
  assign code    = src_mdm ? 3'b001 : src_rx ? 3'b010 : src_tx ? 3'b011 : 3'b000;
  assign irq_o   = src_mdm || src_rx || src_tx;

  assign lsr = {1'b0, tx_idle_i, tx_room_i, 1'b0, rx_frame_err_i, 1'b0, rx_overrun_i, rx_ready_i};
  assign msr = {dcd_s, ri_s, dsr_s, cts_s, dcd_chg, 3'b000};
  assign isr = {irq_o, 2'b00, code, 2'b00};

  always_comb begin
    case (adr_i)
      4'd0:  rd_mux = rx_data_i;
      4'd1:  rd_mux = lsr;
      4'd2:  rd_mux = msr;
      4'd3:  rd_mux = isr;
      4'd4:  rd_mux = ier;
      4'd5:  rd_mux = ffr;
      4'd6:  rd_mux = mcr;
      4'd7:  rd_mux = ctl;
      4'd8:  rd_mux = clk_mul_o[7:0];
      4'd9:  rd_mux = clk_mul_o[15:8];
      4'd10: rd_mux = clk_mul_o[23:16];
      4'd11: rd_mux = clk_mul_o[31:24];
      4'd12: rd_mux = fcr;
      4'd15: rd_mux = spr;
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ack_o     <= 1'b0;
      dat_o     <= '0;
      rx_pop_o  <= 1'b0;
      tx_load_o <= 1'b0;
      tx_data_o <= '0;
    end else begin
      ack_o     <= acc;
      rx_pop_o  <= rd && adr_i == 4'd0;
      tx_load_o <= wr && adr_i == 4'd0;
      if (rd) dat_o <= rd_mux;
      if (wr && adr_i == 4'd0) tx_data_o <= dat_i;
    end
  end

  assign dtr_no     = ~mcr[0];
  assign rts_no     = ~mcr[1];
  assign tx_allow_o = !ctl[0] || cts_s;

  a_r1_ack_follows_req: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ack_o) |-> $past(cyc_i && stb_i));
  a_r2_pop_on_read0: assert property (@(posedge clk_i) disable iff (rst_i)
    rx_pop_o |-> ack_o && !$past(we_i) && $past(adr_i) == 4'd0);
  a_r2_load_with_ack: assert property (@(posedge clk_i) disable iff (rst_i)
    tx_load_o |-> ack_o && $past(we_i));
  a_r5_clear_without_edge: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(wr && adr_i == 4'd2 && dcd_s == dcd_prev) |-> !dcd_chg);
  a_r5_edge_sets: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(dcd_s != dcd_prev) |-> dcd_chg);
  a_r7_quiet_when_disabled: assert property (@(posedge clk_i) disable iff (rst_i)
    (ier[3] == 1'b0 && ier[1:0] == 2'b00) |-> !irq_o);
  a_r9_flow_gate: assert property (@(posedge clk_i) disable iff (rst_i)
    (ctl[0] && !cts_s) |-> !tx_allow_o);
  a_r12_no_stray_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
    (rx_pop_o || tx_load_o) |-> $past(adr_i) == 4'd0);

endmodule

// File: tb/uart_regbank_tb.sv
module uart_regbank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc = 0, stb = 0, we = 0;
  logic [3:0]  adr = 0;
  logic [7:0]  wdat = 0;
  logic [7:0]  dat_o;
  logic        ack, irq;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_ready = 0, rx_ovr = 0, rx_ferr = 0, tx_room = 0, tx_idle = 0;
  logic        rx_pop, tx_load, tx_allow;
  logic [7:0]  tx_data;
  logic [31:0] clk_mul;
  logic        cts_n = 1, dsr_n = 1, dcd_n = 1, ri_n = 1;
  logic        dtr_n, rts_n;
  int checks = 0, errors = 0, pops = 0, loads = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  uart_regbank u_dut (
    .clk_i(clk), .rst_i(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we), .adr_i(adr),
    .dat_i(wdat), .dat_o(dat_o), .ack_o(ack), .irq_o(irq),
    .rx_data_i(rx_data), .rx_ready_i(rx_ready), .rx_overrun_i(rx_ovr),
    .rx_frame_err_i(rx_ferr), .rx_pop_o(rx_pop), .tx_room_i(tx_room),
    .tx_idle_i(tx_idle), .tx_load_o(tx_load), .tx_data_o(tx_data),
    .tx_allow_o(tx_allow), .clk_mul_o(clk_mul), .cts_ni(cts_n), .dsr_ni(dsr_n),
    .dcd_ni(dcd_n), .ri_ni(ri_n), .dtr_no(dtr_n), .rts_no(rts_n));

  always @(negedge clk) begin
    if (rx_pop) pops++;
    if (tx_load) loads++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [3:0] a, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = a; wdat = d;
    check("R1 no early ack", ack, 0);
    @(negedge clk);
    check("R1 ack", ack, 1);
    q = dat_o;
    cyc = 0; stb = 0; we = 0;
    @(negedge clk);
    check("R1 ack single", ack, 0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] q;
    bus(1'b1, a, d, q);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R8 dtr reset active", dtr_n, 0);
    check("R8 rts reset active", rts_n, 0);
    check("R10 mul reset", clk_mul, 32'h0003_2A10);
    check("R9 allow reset", tx_allow, 1);
    check("R7 irq reset", irq, 0);
  endtask

  task automatic t_data();
    int p0, l0;
    p0 = pops; l0 = loads;
    wr(4'd0, 8'hA5);
    check("R2 tx data", tx_data, 8'hA5);
    check("R2 one load", loads - l0, 1);
    rx_data = 8'h3C;
    bus(1'b0, 4'd0, 8'h00, rv);
    check("R2 rx data", rv, 8'h3C);
    check("R2 one pop", pops - p0, 1);
  endtask

  task automatic t_line();
    int p0;
    p0 = pops;
    rx_ready = 1; rx_ovr = 1; rx_ferr = 1; tx_room = 1; tx_idle = 1;
    bus(1'b0, 4'd1, 8'h00, rv);
    check("R3 all set", rv, 8'h6B);
    rx_ready = 0; rx_ovr = 0; rx_ferr = 0; tx_idle = 0;
    bus(1'b0, 4'd1, 8'h00, rv);
    check("R3 room only", rv, 8'h20);
    check("R12 no pop on status read", pops - p0, 0);
  endtask

  task automatic t_modem();
    bus(1'b0, 4'd2, 8'h00, rv);
    check("R4 idle", rv, 8'h00);
    cts_n = 0; dsr_n = 0; ri_n = 0;
    settle();
    bus(1'b0, 4'd2, 8'h00, rv);
    check("R4 levels", rv, 8'h70);
    dcd_n = 0;
    settle();
    bus(1'b0, 4'd2, 8'h00, rv);
    check("R5 change set", rv, 8'hF8);
    wr(4'd2, 8'h00);
    bus(1'b0, 4'd2, 8'h00, rv);
    check("R5 cleared by write", rv, 8'hF0);
  endtask

  task automatic t_collide();
    @(negedge clk);
    dcd_n = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    cyc = 1; stb = 1; we = 1; adr = 4'd2; wdat = 8'h00;
    @(negedge clk);
    cyc = 0; stb = 0; we = 0;
    @(negedge clk);
    bus(1'b0, 4'd2, 8'h00, rv);
    check("R5 edge beats clear", rv, 8'h78);
    wr(4'd4, 8'h08);
    bus(1'b0, 4'd3, 8'h00, rv);
    check("R7 modem code", rv, 8'h84);
    wr(4'd2, 8'h00);
    bus(1'b0, 4'd2, 8'h00, rv);
    check("R5 later clear", rv, 8'h70);
  endtask

  task automatic t_irq();
    wr(4'd4, 8'h00);
    rx_ready = 1; tx_idle = 1;
    @(negedge clk);
    check("R7 disabled no irq", irq, 0);
    wr(4'd4, 8'h0B);
    bus(1'b0, 4'd4, 8'h00, rv);
    check("R6 enable readback", rv, 8'h0B);
    bus(1'b0, 4'd3, 8'h00, rv);
    check("R7 rx over tx", rv, 8'h88);
    check("R7 irq high", irq, 1);
    rx_ready = 0;
    bus(1'b0, 4'd3, 8'h00, rv);
    check("R7 tx code", rv, 8'h8C);
    dcd_n = 0;
    settle();
    rx_ready = 1;
    bus(1'b0, 4'd3, 8'h00, rv);
    check("R7 modem highest", rv, 8'h84);
    wr(4'd2, 8'h00);
    rx_ready = 0; tx_idle = 0;
    @(negedge clk);
    bus(1'b0, 4'd3, 8'h00, rv);
    check("R7 none pending", rv, 8'h00);
    check("R7 irq low", irq, 0);
  endtask

  task automatic t_ctrl();
    wr(4'd6, 8'h02);
    check("R8 dtr off", dtr_n, 1);
    check("R8 rts on", rts_n, 0);
    bus(1'b0, 4'd6, 8'h00, rv);
    check("R8 readback", rv, 8'h02);
    cts_n = 1;
    settle();
    check("R9 allow off ctl", tx_allow, 1);
    wr(4'd7, 8'h01);
    check("R9 gated", tx_allow, 0);
    cts_n = 0;
    settle();
    check("R9 cts opens", tx_allow, 1);
  endtask

  task automatic t_misc();
    int p0, l0;
    p0 = pops; l0 = loads;
    wr(4'd8, 8'h11); wr(4'd9, 8'h22); wr(4'd10, 8'h33); wr(4'd11, 8'h44);
    check("R10 mul", clk_mul, 32'h4433_2211);
    bus(1'b0, 4'd10, 8'h00, rv);
    check("R10 readback", rv, 8'h33);
    wr(4'd5, 8'h5A); wr(4'd12, 8'hC3); wr(4'd15, 8'h96); wr(4'd13, 8'hFF);
    bus(1'b0, 4'd5, 8'h00, rv);  check("R11 addr5", rv, 8'h5A);
    bus(1'b0, 4'd12, 8'h00, rv); check("R11 addr12", rv, 8'hC3);
    bus(1'b0, 4'd15, 8'h00, rv); check("R11 scratch", rv, 8'h96);
    bus(1'b0, 4'd13, 8'h00, rv); check("R11 reserved", rv, 8'h00);
    check("R12 no pop", pops - p0, 0);
    check("R12 no load", loads - l0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_data();
    t_line();
    t_modem();
    t_collide();
    t_irq();
    t_ctrl();
    t_misc();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule